// File: doc/BRIEF.md
# Packet-over-SONET HDLC Transmit Framer

This block turns a stream of packet bytes into the continuous byte stream that fills a SONET payload envelope. A packet source presents one byte at a time with start, end and error marks. The block wraps each packet between flag bytes and appends a 16-bit or 32-bit frame check sequence, or none. It escapes any byte that a receiver could mistake for a flag or an escape. Flags fill the line while no frame is being sent.

The mapper downstream asks for one byte per cycle through a request strobe and may leave gaps between requests. Each request produces exactly one output byte one cycle later. A packet that runs dry mid-frame, or whose last byte is marked errored, is closed with an abort sequence so that the line never carries a malformed frame. An abort counter records each such event. The whole output, flags included, can pass through a self-synchronous x^43+1 scrambler.

Top module: `pos_tx_framer`

## Requirements
- R1: While no frame is in progress and no start-marked byte is offered, every requested output byte is the flag 0x7E.
- R2: A packet whose first byte carries the start mark is sent after a flag, as its bytes in order, followed by the check sequence (if any) and a closing flag 0x7E.
- R3: cfg_fcs_mode_i selects the check sequence: 2'b01 gives CRC-16 (reflected polynomial 0x8408, preset 0xFFFF), 2'b10 gives CRC-32 (reflected polynomial 0xEDB88320, preset all ones), and 2'b00 or 2'b11 gives none. The sequence covers the unescaped packet bytes and is sent complemented, least significant byte first. For the nine ASCII bytes "123456789" it is 6E 90 (16-bit) or 26 39 F4 CB (32-bit).
- R4: A payload or check-sequence byte equal to 0x7E or 0x7D is sent as the escape 0x7D followed by the byte XOR 0x20.
- R5: If the end-marked byte also carries the error mark, that byte is sent and then followed by 0x7D, 0x7E in place of the check sequence. An idle flag follows, and abort_cnt_o increases by one.
- R6: If a byte is requested mid-frame while pkt_valid_i is low, the frame is cut with 0x7D, 0x7E, followed by an idle flag, and abort_cnt_o increases by one.
- R7: Outside a frame, offered bytes without the start mark are consumed and dropped; the line keeps sending flags.
- R8: Two frames offered back to back are separated by exactly one flag.
- R9: When cfg_scr_en_i is high, every output byte is scrambled with x^43+1, most significant bit first, starting from an all-zero state after reset. The scrambler advances only on requested bytes. When cfg_scr_en_i is low, bytes leave unscrambled.
- R10: tx_valid_o is high exactly in the cycle after each cycle with out_req_i high, carrying that slot's byte. pkt_ready_o is high only in cycles with out_req_i high, and a byte is taken at the clock edge that ends such a cycle.
- R11: In reset, tx_valid_o is low and abort_cnt_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fcs_mode_i | input | 2 | Check sequence select: 01 CRC-16, 10 CRC-32, else none |
| cfg_scr_en_i | input | 1 | Enable x^43+1 scrambling of the output |
| out_req_i | input | 1 | Payload byte request from the mapper |
| pkt_valid_i | input | 1 | Packet byte offered |
| pkt_data_i | input | 8 | Packet byte |
| pkt_sop_i | input | 1 | Offered byte starts a packet |
| pkt_eop_i | input | 1 | Offered byte ends a packet |
| pkt_err_i | input | 1 | Packet ending here is errored (valid with end mark) |
| pkt_ready_o | output | 1 | Offered byte is taken at this clock edge |
| tx_data_o | output | 8 | Output payload byte |
| tx_valid_o | output | 1 | tx_data_o carries a requested byte |
| abort_cnt_o | output | CNT_W | Number of aborted frames, wrapping |

## Verification
The assertions take for granted that the source holds a byte and its marks steady until pkt_ready_o takes it, that the error mark is raised only together with the end mark, and that the configuration inputs stay still between resets. The directed stimulus honours all three: each byte is driven just after a clock edge and kept until the design has taken it, error marks ride only on last bytes, and every scenario sets its configuration during reset. Underruns are produced only by dropping pkt_valid_i mid-frame.

// File: rtl/pos_tx_pkg.sv
package pos_tx_pkg;
  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] ESC_BYTE  = 8'h7D;
  localparam logic [7:0] ESC_MASK  = 8'h20;

  localparam logic [31:0] CRC32_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC16_POLY = 32'h0000_8408;
  localparam logic [31:0] CRC32_INIT = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC16_INIT = 32'h0000_FFFF;

  typedef enum logic [1:0] {
    FCS_NONE = 2'b00,
    FCS_16   = 2'b01,
    FCS_32   = 2'b10,
    FCS_OFF  = 2'b11
  } fcs_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_ESC,
    ST_FCS,
    ST_ABORT_ESC,
    ST_ABORT_FLAG
  } tx_state_e;
endpackage

// File: rtl/pos_octet_esc.sv
module pos_octet_esc
  import pos_tx_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output logic [7:0] esc_o
);
  assign hit_o = (byte_i == FLAG_BYTE) || (byte_i == ESC_BYTE);
  assign esc_o = byte_i ^ ESC_MASK;
endmodule

// File: rtl/pos_fcs_gen.sv
module pos_fcs_gen
  import pos_tx_pkg::*;
#(
  parameter int unsigned CRC_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  fcs_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] poly;

  assign poly = wide_i ? CRC_W'(CRC32_POLY) : CRC_W'(CRC16_POLY);

  // reflected bitwise update, LSB of data first
  always_comb begin
    logic fb;
    crc_d = crc_q;
    for (int i = 0; i < BYTE_W; i++) begin
      fb    = crc_d[0] ^ data_i[i];
      crc_d = crc_d >> 1;
      if (fb) crc_d = crc_d ^ poly;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (init_i)  crc_q <= wide_i ? CRC_W'(CRC32_INIT) : CRC_W'(CRC16_INIT);
    else if (upd_i)   crc_q <= crc_d;
  end

  assign fcs_o = wide_i ? ~crc_q : {{(CRC_W-16){1'b0}}, ~crc_q[15:0]};
endmodule

// File: rtl/pos_scrambler.sv
module pos_scrambler #(
  parameter int unsigned TAP_W  = 43,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [TAP_W-1:0]  hist_q, hist_d;
  logic [BYTE_W-1:0] scr;

  // MSB first; history holds transmitted bits
  always_comb begin
    hist_d = hist_q;
    scr    = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      scr[i] = data_i[i] ^ hist_d[TAP_W-1];
      hist_d = {hist_d[TAP_W-2:0], scr[i]};
    end
  end

  assign data_o = en_i ? scr : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hist_q <= '0;
    else if (adv_i && en_i) hist_q <= hist_d;
  end

  p_scr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(hist_q));
endmodule

// File: rtl/pos_tx_framer.sv
module pos_tx_framer
  import pos_tx_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP_W = 43
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_fcs_mode_i,
  input  logic             cfg_scr_en_i,
  input  logic             out_req_i,
  input  logic             pkt_valid_i,
  input  logic [7:0]       pkt_data_i,
  input  logic             pkt_sop_i,
  input  logic             pkt_eop_i,
  input  logic             pkt_err_i,
  output logic             pkt_ready_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  output logic [CNT_W-1:0] abort_cnt_o
);
  localparam int unsigned CRC_W = 32;
  localparam int unsigned IDX_W = $clog2(CRC_W / 8);

  tx_state_e        state_q, state_d, ret_q, ret_d;
  logic [7:0]       esc_q, esc_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] abort_cnt_q;
  logic             last_esc_q;
  logic [7:0]       tx_data_q;
  logic             tx_valid_q;

  logic             fcs_en, fcs_wide;
  logic [IDX_W-1:0] idx_last;
  logic [CRC_W-1:0] fcs_w;
  logic [7:0]       fcs_byte;
  logic             crc_init, crc_upd, abort_inc;
  logic [7:0]       raw, scr_byte;
  logic             d_hit, f_hit;
  logic [7:0]       d_esc, f_esc;
  tx_state_e        after_data, after_fcs;

  assign fcs_wide = (cfg_fcs_mode_i == FCS_32);
  assign fcs_en   = (cfg_fcs_mode_i == FCS_16) || fcs_wide;
  assign idx_last = fcs_wide ? IDX_W'(CRC_W/8 - 1) : IDX_W'(1);
  assign fcs_byte = fcs_w[{idx_q, 3'b000} +: 8];

  pos_octet_esc u_data_esc (.byte_i(pkt_data_i), .hit_o(d_hit), .esc_o(d_esc));
  pos_octet_esc u_fcs_esc  (.byte_i(fcs_byte),   .hit_o(f_hit), .esc_o(f_esc));

  pos_fcs_gen #(.CRC_W(CRC_W), .BYTE_W(8)) u_fcs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wide_i (fcs_wide),
    .init_i (crc_init),
    .upd_i  (crc_upd),
    .data_i (pkt_data_i),
    .fcs_o  (fcs_w)
  );

  always_comb begin
    if (!pkt_eop_i)     after_data = ST_DATA;
    else if (pkt_err_i) after_data = ST_ABORT_ESC;
    else if (fcs_en)    after_data = ST_FCS;
    else                after_data = ST_IDLE;
    after_fcs = (idx_q == idx_last) ? ST_IDLE : ST_FCS;
  end

  always_comb begin
    state_d     = state_q;
    ret_d       = ret_q;
    esc_d       = esc_q;
    idx_d       = idx_q;
    raw         = FLAG_BYTE;
    pkt_ready_o = 1'b0;
    crc_init    = 1'b0;
    crc_upd     = 1'b0;
    abort_inc   = 1'b0;
    if (out_req_i) begin
      unique case (state_q)
        ST_IDLE: begin
          crc_init = 1'b1;
          if (pkt_valid_i) begin
            if (pkt_sop_i) state_d = ST_DATA;
            else           pkt_ready_o = 1'b1;  // stray byte, dropped
          end
        end
        ST_DATA: begin
          idx_d = '0;
          if (!pkt_valid_i) begin
            raw       = ESC_BYTE;
            abort_inc = 1'b1;
            state_d   = ST_ABORT_FLAG;
          end else begin
            pkt_ready_o = 1'b1;
            crc_upd     = 1'b1;
            if (d_hit) begin
              raw     = ESC_BYTE;
              esc_d   = d_esc;
              ret_d   = after_data;
              state_d = ST_ESC;
            end else begin
              raw     = pkt_data_i;
              state_d = after_data;
            end
          end
        end
        ST_ESC: begin
          raw     = esc_q;
          state_d = ret_q;
        end
        ST_FCS: begin
          idx_d = idx_q + 1'b1;
          if (f_hit) begin
            raw     = ESC_BYTE;
            esc_d   = f_esc;
            ret_d   = after_fcs;
            state_d = ST_ESC;
          end else begin
            raw     = fcs_byte;
            state_d = after_fcs;
          end
        end
        ST_ABORT_ESC: begin
          raw       = ESC_BYTE;
          abort_inc = 1'b1;
          state_d   = ST_ABORT_FLAG;
        end
        ST_ABORT_FLAG: begin
          raw     = FLAG_BYTE;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  pos_scrambler #(.TAP_W(TAP_W), .BYTE_W(8)) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_scr_en_i),
    .adv_i  (out_req_i),
    .data_i (raw),
    .data_o (scr_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ret_q       <= ST_IDLE;
      esc_q       <= '0;
      idx_q       <= '0;
      abort_cnt_q <= '0;
      last_esc_q  <= 1'b0;
      tx_data_q   <= '0;
      tx_valid_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      ret_q       <= ret_d;
      esc_q       <= esc_d;
      idx_q       <= idx_d;
      abort_cnt_q <= abort_cnt_q + CNT_W'(abort_inc);
      tx_valid_q  <= out_req_i;
      if (out_req_i) begin
        tx_data_q  <= scr_byte;
        last_esc_q <= (raw == ESC_BYTE);
      end
    end
  end

  assign tx_data_o   = tx_data_q;
  assign tx_valid_o  = tx_valid_q;
  assign abort_cnt_o = abort_cnt_q;

  p_escape_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_i && last_esc_q) |-> (raw == 8'h5E || raw == 8'h5D || raw == FLAG_BYTE));

  p_underrun_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_i && state_q == ST_DATA && !pkt_valid_i)
      |=> (abort_cnt_o == $past(abort_cnt_o) + 1'b1));

  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_cnt_o != $past(abort_cnt_o)) |-> (abort_cnt_o == $past(abort_cnt_o) + 1'b1));

  p_valid_on_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_req_i |=> tx_valid_o);

  p_no_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_req_i |=> !tx_valid_o);
endmodule

// File: tb/pos_tx_framer_tb.sv
`timescale 1ns/1ps
module pos_tx_framer_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fcs_mode = 2'b00;
  logic scr_en = 1'b0;
  logic out_req = 1'b0;
  logic pkt_valid = 1'b0;
  logic [7:0] pkt_data = 8'h00;
  logic pkt_sop = 1'b0, pkt_eop = 1'b0, pkt_err = 1'b0;
  logic pkt_ready;
  logic [7:0] tx_data;
  logic tx_valid;
  logic [CNT_W-1:0] abort_cnt;

  int checks = 0;
  int errors = 0;

  logic [7:0] cap[$];
  logic [7:0] an[$];
  logic [7:0] src[0:15];
  logic [7:0] exp_b[0:31];
  int exp_n;

  always #5 clk = ~clk;

  pos_tx_framer #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_fcs_mode_i(fcs_mode), .cfg_scr_en_i(scr_en),
    .out_req_i(out_req), .pkt_valid_i(pkt_valid), .pkt_data_i(pkt_data),
    .pkt_sop_i(pkt_sop), .pkt_eop_i(pkt_eop), .pkt_err_i(pkt_err),
    .pkt_ready_o(pkt_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .abort_cnt_o(abort_cnt)
  );

  always @(negedge clk) if (rst_n && tx_valid) cap.push_back(tx_data);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic scr);
    @(negedge clk);
    rst_n = 1'b0; fcs_mode = mode; scr_en = scr; out_req = 1'b0;
    pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0; pkt_err = 1'b0;
    repeat (3) @(negedge clk);
    cap.delete();
    rst_n = 1'b1;
  endtask

  task automatic push_byte(input logic [7:0] d, input logic s, input logic e, input logic r);
    logic got;
    pkt_valid = 1'b1; pkt_data = d; pkt_sop = s; pkt_eop = e; pkt_err = r;
    do begin
      @(negedge clk); #1;
      got = pkt_ready;
    end while (!got);
    @(posedge clk); #1;
    pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0; pkt_err = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic err_last);
    for (int i = 0; i < n; i++)
      push_byte(src[i], i == 0, i == n - 1, err_last && (i == n - 1));
  endtask

  task automatic load_digits();
    for (int i = 0; i < 9; i++) src[i] = 8'h31 + 8'(i);
    for (int i = 0; i < 9; i++) exp_b[i] = 8'h31 + 8'(i);
  endtask

  // compare the first frame after leading flags in 'an' with exp_b
  task automatic check_frame(input string req, output int k_end);
    int k = 0;
    while (k < an.size() && an[k] == 8'h7E) k++;
    for (int j = 0; j < exp_n; j++)
      chk(req, (k + j < an.size()) ? {24'h0, an[k + j]} : 32'hFFFF_FFFF, {24'h0, exp_b[j]});
    k_end = k + exp_n;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; #3;
    chk("R11 tx_valid in reset", tx_valid, 0);
    chk("R11 abort_cnt in reset", abort_cnt, 0);
    do_reset(2'b00, 1'b0);
    pkt_valid = 1'b1; pkt_data = 8'h55; #1;
    chk("R10 no ready without request", pkt_ready, 0);
    repeat (3) @(negedge clk);
    chk("R10 no output without request", cap.size(), 0);
    pkt_valid = 1'b0;
  endtask

  task automatic t_idle();
    int nreq = 0;
    int bad = 0;
    do_reset(2'b01, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      out_req = (i % 3 != 0);
      if (out_req) nreq++;
    end
    @(negedge clk); out_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 one byte per request", cap.size(), nreq);
    foreach (cap[i]) if (cap[i] != 8'h7E) bad++;
    chk("R1 idle flags", bad, 0);
  endtask

  task automatic run_frame(input logic [1:0] mode, input int n, input logic err, input string req);
    int ke;
    do_reset(mode, 1'b0);
    @(negedge clk); out_req = 1'b1;
    repeat (2) @(negedge clk);
    send_pkt(n, err);
    repeat (12) @(negedge clk);
    out_req = 1'b0;
    @(negedge clk);
    an = cap;
    check_frame(req, ke);
  endtask

  task automatic t_fcs16();
    load_digits();
    exp_b[9] = 8'h6E; exp_b[10] = 8'h90; exp_b[11] = 8'h7E; exp_n = 12;
    run_frame(2'b01, 9, 1'b0, "R2 R3 crc16 frame");
  endtask

  task automatic t_fcs32();
    load_digits();
    exp_b[9] = 8'h26; exp_b[10] = 8'h39; exp_b[11] = 8'hF4; exp_b[12] = 8'hCB;
    exp_b[13] = 8'h7E; exp_n = 14;
    run_frame(2'b10, 9, 1'b0, "R3 crc32 frame");
  endtask

  task automatic t_stuff();
    src[0] = 8'h01; src[1] = 8'h7E; src[2] = 8'h7D; src[3] = 8'h20; src[4] = 8'h5A;
    exp_b[0] = 8'h01; exp_b[1] = 8'h7D; exp_b[2] = 8'h5E; exp_b[3] = 8'h7D;
    exp_b[4] = 8'h5D; exp_b[5] = 8'h20; exp_b[6] = 8'h5A; exp_b[7] = 8'h7E;
    exp_n = 8;
    run_frame(2'b00, 5, 1'b0, "R4 stuffing, R3 no fcs");
  endtask

  task automatic t_err();
    src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33;
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h33; exp_b[3] = 8'h7D;
    exp_b[4] = 8'h7E; exp_b[5] = 8'h7E; exp_n = 6;
    run_frame(2'b01, 3, 1'b1, "R5 errored packet abort");
    chk("R5 abort count", abort_cnt, 1);
  endtask

  task automatic t_underrun();
    int ke;
    int bad = 0;
    do_reset(2'b01, 1'b0);
    @(negedge clk); out_req = 1'b1;
    repeat (2) @(negedge clk);
    push_byte(8'h11, 1'b1, 1'b0, 1'b0);
    push_byte(8'h22, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    push_byte(8'h33, 1'b0, 1'b0, 1'b0);
    push_byte(8'h44, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    out_req = 1'b0;
    @(negedge clk);
    an = cap;
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h7D; exp_b[3] = 8'h7E;
    exp_b[4] = 8'h7E; exp_n = 5;
    check_frame("R6 underrun abort", ke);
    chk("R6 abort count", abort_cnt, 1);
    for (int i = ke; i < an.size(); i++) if (an[i] != 8'h7E) bad++;
    chk("R7 stray bytes dropped", bad, 0);
  endtask

  task automatic t_b2b();
    int ke;
    do_reset(2'b00, 1'b0);
    @(negedge clk); out_req = 1'b1;
    repeat (2) @(negedge clk);
    push_byte(8'h0A, 1'b1, 1'b1, 1'b0);
    push_byte(8'h0B, 1'b1, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    out_req = 1'b0;
    @(negedge clk);
    an = cap;
    exp_b[0] = 8'h0A; exp_b[1] = 8'h7E; exp_b[2] = 8'h0B; exp_b[3] = 8'h7E; exp_n = 4;
    check_frame("R8 one flag between frames", ke);
  endtask

  task automatic t_scr();
    int ke;
    int diff = 0;
    logic [42:0] s;
    logic [7:0] d;
    load_digits();
    exp_b[9] = 8'h6E; exp_b[10] = 8'h90; exp_b[11] = 8'h7E; exp_n = 12;
    do_reset(2'b01, 1'b1);
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          @(negedge clk);
          out_req = (i % 4 != 1);
        end
        @(negedge clk); out_req = 1'b1;
        repeat (10) @(negedge clk);
        out_req = 1'b0;
        @(negedge clk);
      end
      begin
        repeat (3) @(negedge clk);
        send_pkt(9, 1'b0);
      end
    join
    s = '0;
    an.delete();
    foreach (cap[i]) begin
      for (int b = 7; b >= 0; b--) begin
        d[b] = cap[i][b] ^ s[42];
        s = {s[41:0], cap[i][b]};
      end
      an.push_back(d);
      if (d != cap[i]) diff++;
    end
    check_frame("R9 descrambled frame", ke);
    chk("R9 scrambling changes line", diff > 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_fcs16();
    t_fcs32();
    t_stuff();
    t_err();
    t_underrun();
    t_b2b();
    t_scr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule